// File: doc/BRIEF.md
# Serial Flash Boot Copier

This block copies a fixed-size image from a serial Flash device into on-chip SRAM without any software involvement. It decides once, on the first clock after reset is released, whether to run. If it runs, it opens one SPI frame and sends the standard read opcode followed by a 24-bit address of zero. It then clocks in the requested number of bytes and hands each one to the SRAM write port at the configured base address plus the byte offset.

The SPI side works in mode 0. SCK idles low, MOSI changes while SCK is low, and MISO is sampled on the rising edge. The SCK half-period is a parameter counted in system clocks.

The SRAM side is a valid/ready write port that carries one byte per beat. The block raises `mem_valid` with the address and data and holds all three unchanged until it samples `mem_ready` high at a clock edge. It does not clock the SPI bus while a byte is waiting, so a slow SRAM only stretches the SPI frame and loses no data.

Top module: `spi_boot_copier`

## Requirements
- R1: With `boot_en` high at reset release, the first 32 SCK rising edges of the frame carry 8'h03 and then 24 zero bits on MOSI, MSB first. SCK is low when idle, and MOSI is sampled on the rising edge.
- R2: Each following group of 8 MISO bits, sampled MSB first on rising SCK edges, is written as one beat with `mem_addr` equal to SRAM_BASE plus the byte offset. Offsets run 0 to COPY_BYTES-1 in order.
- R3: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` stay unchanged. SCK stays low while `mem_valid` is high.
- R4: `spi_cs_n` falls once per copy, stays low for the whole copy, and is high again in the cycle `done` is asserted.
- R5: `done` is a single-cycle pulse. It is asserted once per reset, in the cycle after the last write beat is accepted.
- R6: `busy` is high from reset release until `done` rises and low from then on.
- R7: With `boot_en` low at reset release, `spi_cs_n` never falls and no write beat occurs. `done` pulses on the second clock edge after reset release.
- R8: A change of `boot_en` after reset release has no effect on a copy that has already started.
- R9: With COPY_BYTES equal to 0, `spi_cs_n` never falls, and `done` pulses on the second clock edge after release.
- R10: SCK is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Sampled at reset release; high runs the copy |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the Flash |
| spi_miso | input | 1 | Serial data from the Flash |
| mem_valid | output | 1 | Write beat pending |
| mem_ready | input | 1 | SRAM accepts the beat at this clock edge |
| mem_addr | output | ADDR_W | SRAM byte address |
| mem_data | output | 8 | SRAM write byte |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a write beat that is held back while the SPI frame is open and SCK is paused halfway through the image. If that pause is mishandled, one byte can be dropped or written twice. The bench drives `mem_ready` from an irregular pattern, so beats are stalled for one or several cycles at many offsets. In the same run it flips `boot_en` while the copy is in progress. A behavioural Flash model answers the SPI frame, and every accepted beat is compared with the byte the model served at that offset.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_HDR,
    ST_DATA,
    ST_WRITE,
    ST_FIN,
    ST_OFF
  } boot_state_t;

  localparam logic [7:0] READ_OPCODE = 8'h03;
  localparam int HDR_BYTES = 4;
endpackage

// File: rtl/spi_boot_tick.sv
module spi_boot_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || cnt == TOP) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == TOP);
endmodule

// File: rtl/spi_boot_shifter.sv
module spi_boot_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       active
);
  logic [7:0] sh_out;
  logic [2:0] bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sck       <= 1'b0;
      sh_out    <= '0;
      rx_byte   <= '0;
      bitn      <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sck    <= 1'b0;
        sh_out <= tx_byte;
        bitn   <= '0;
      end else if (active && tick) begin
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bitn   <= bitn + 1'b1;
            sh_out <= {sh_out[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = sh_out[7];

  p_sck_only_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sck || active);
endmodule

// File: rtl/spi_boot_seq.sv
module spi_boot_seq
  import spi_boot_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int unsigned BASE = 'h0200,
  parameter int NBYTES    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic              mem_ready,
  output logic              start,
  output logic [7:0]        tx_byte,
  output logic              cs_n,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              busy,
  output logic              done
);
  localparam int OW = (NBYTES > 0) ? (($clog2(NBYTES + 1) > 0) ? $clog2(NBYTES + 1) : 1) : 1;
  localparam logic [OW-1:0] LAST_OFF = OW'((NBYTES > 0) ? NBYTES - 1 : 0);
  localparam logic [1:0]    LAST_HDR = 2'(HDR_BYTES - 1);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam bit RUNNABLE = (NBYTES > 0);

  boot_state_t st;
  logic [1:0]    hdr_idx;
  logic [OW-1:0] off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_START;
      cs_n      <= 1'b1;
      start     <= 1'b0;
      tx_byte   <= '0;
      hdr_idx   <= '0;
      off       <= '0;
      mem_valid <= 1'b0;
      mem_data  <= '0;
    end else begin
      start <= 1'b0;
      case (st)
        ST_START: begin
          if (boot_en && RUNNABLE) begin
            cs_n    <= 1'b0;
            start   <= 1'b1;
            tx_byte <= READ_OPCODE;
            hdr_idx <= '0;
            st      <= ST_HDR;
          end else begin
            st <= ST_FIN;
          end
        end
        ST_HDR: begin
          if (byte_done) begin
            tx_byte <= '0;
            start   <= 1'b1;
            if (hdr_idx == LAST_HDR) st <= ST_DATA;
            else hdr_idx <= hdr_idx + 1'b1;
          end
        end
        ST_DATA: begin
          if (byte_done) begin
            mem_data  <= rx_byte;
            mem_valid <= 1'b1;
            st        <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            if (off == LAST_OFF) begin
              cs_n <= 1'b1;
              st   <= ST_FIN;
            end else begin
              off     <= off + 1'b1;
              start   <= 1'b1;
              tx_byte <= '0;
              st      <= ST_DATA;
            end
          end
        end
        ST_FIN:  st <= ST_OFF;
        default: st <= ST_OFF;
      endcase
    end
  end

  assign mem_addr = BASE_A + ADDR_W'(off);
  assign done     = (st == ST_FIN);
  assign busy     = (st != ST_FIN) && (st != ST_OFF);

  p_hold_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_cs_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  p_no_busy_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
endmodule

// File: rtl/spi_boot_copier.sv
module spi_boot_copier #(
  parameter int ADDR_W     = 16,
  parameter int unsigned SRAM_BASE = 'h0200,
  parameter int COPY_BYTES = 12,
  parameter int SCK_HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              busy,
  output logic              done
);
  logic       start;
  logic [7:0] tx_byte;
  logic       tick;
  logic       active;
  logic [7:0] rx_byte;
  logic       byte_done;

  spi_boot_seq #(
    .ADDR_W(ADDR_W),
    .BASE  (SRAM_BASE),
    .NBYTES(COPY_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_en  (boot_en),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .mem_ready(mem_ready),
    .start    (start),
    .tx_byte  (tx_byte),
    .cs_n     (spi_cs_n),
    .mem_valid(mem_valid),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .busy     (busy),
    .done     (done)
  );

  spi_boot_tick #(.HALF_DIV(SCK_HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active),
    .tick (tick)
  );

  spi_boot_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_byte  (tx_byte),
    .tick     (tick),
    .miso     (spi_miso),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .rx_byte  (rx_byte),
    .byte_done(byte_done),
    .active   (active)
  );

  p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_no_sck_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !spi_sck);
endmodule

// File: tb/spi_boot_copier_test.sv
module spi_boot_copier_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int BASE = 'h0200;
  localparam int N    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_en = 1'b1;
  logic mem_ready = 1'b1;
  logic miso = 1'b0;
  logic sck, cs_n, mosi, mem_valid, busy, done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic e_sck, e_cs_n, e_mosi, e_valid, e_busy, e_done;
  logic [AW-1:0] e_addr;
  logic [7:0] e_data;

  int checks = 0;
  int errors = 0;
  int rcnt = 0;
  int cs_falls = 0;
  logic [31:0] hdr_cap = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_boot_copier #(.ADDR_W(AW), .SRAM_BASE(BASE), .COPY_BYTES(N), .SCK_HALF(2)) uut (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .done(done));

  spi_boot_copier #(.ADDR_W(AW), .SRAM_BASE(BASE), .COPY_BYTES(0), .SCK_HALF(2)) uut_empty (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .spi_sck(e_sck), .spi_cs_n(e_cs_n),
    .spi_mosi(e_mosi), .spi_miso(1'b0), .mem_valid(e_valid), .mem_ready(1'b1),
    .mem_addr(e_addr), .mem_data(e_data), .busy(e_busy), .done(e_done));

  function automatic logic [7:0] fbyte(input int i);
    return 8'((i * 53 + 29) ^ (i >> 2));
  endfunction

  // Behavioural Flash: counts rising SCK edges in a frame, captures header
  always @(negedge cs_n or posedge sck) begin
    if (!sck) begin
      rcnt = 0;
      hdr_cap = '0;
      cs_falls = cs_falls + 1;
    end else if (!cs_n) begin
      if (rcnt < 32) hdr_cap = {hdr_cap[30:0], mosi};
      rcnt = rcnt + 1;
    end
  end

  always @(negedge sck) begin
    if (!cs_n && rcnt >= 32) begin
      miso <= fbyte((rcnt - 32) / 8)[7 - ((rcnt - 32) % 8)];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int exp_idx, done_cnt, done_cyc, e_done_cyc, e_cs_low, cyc;
  bit seen_done, pv_valid, pv_ready;
  logic [AW-1:0] pv_addr;
  logic [7:0] pv_data;

  task automatic run_copy(input bit en, input bit stall, input bit flip);
    rst_n = 1'b0;
    boot_en = en;
    mem_ready = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(cs_n && !sck && !mem_valid && !done, "reset state", {cs_n, sck, mem_valid, done}, 4'b1000);
    end
    cs_falls = 0;
    exp_idx = 0; done_cnt = 0; done_cyc = -1; e_done_cyc = -1; e_cs_low = 0;
    seen_done = 0; pv_valid = 0; pv_ready = 1;
    cyc = 0;
    rst_n = 1'b1;
    while (cyc < 5000 && !(seen_done && cyc > done_cyc + 20)) begin
      @(negedge clk);
      cyc++;
      if (flip && cyc == 60) boot_en = ~boot_en;            // R8
      if (pv_valid && !pv_ready)
        check(mem_valid && mem_addr == pv_addr && mem_data == pv_data, "R3 hold",
              {mem_valid, mem_addr, mem_data}, {1'b1, pv_addr, pv_data});
      if (mem_valid) check(!sck, "R3 sck paused", sck, 0);
      if (cs_n) check(!sck, "R10", sck, 0);
      check(busy == !(seen_done || done), "R6 busy", busy, !(seen_done || done));
      if (!e_cs_n) e_cs_low++;
      if (e_done) e_done_cyc = cyc;
      if (done) begin
        done_cnt++;
        if (done_cyc < 0) done_cyc = cyc;
        check(cs_n, "R4 cs released at done", cs_n, 1);
        check(exp_idx == (en ? N : 0), "R5 done after last beat", exp_idx, en ? N : 0);
      end
      if (done) seen_done = 1;
      mem_ready = stall ? (((cyc * 5) % 7) < 3) : 1'b1;
      if (mem_valid && mem_ready) begin
        check(mem_addr == AW'(BASE + exp_idx) && mem_data == fbyte(exp_idx), "R2 beat",
              {mem_addr, mem_data}, {AW'(BASE + exp_idx), fbyte(exp_idx)});
        exp_idx++;
      end
      pv_valid = mem_valid; pv_ready = mem_ready; pv_addr = mem_addr; pv_data = mem_data;
    end
    check(seen_done, "watchdog: done never seen", 0, 1);
    check(done_cnt == 1, "R5 single pulse", done_cnt, 1);
    check(e_cs_low == 0, "R9 empty cs", e_cs_low, 0);
    check(e_done_cyc == 1, "R9 empty done time", e_done_cyc, 1);
    if (en) begin
      check(hdr_cap == 32'h0300_0000, "R1 header", hdr_cap, 32'h0300_0000);
      check(cs_falls == 1, "R4 single frame", cs_falls, 1);
      check(exp_idx == N, "R2 byte count", exp_idx, N);
    end else begin
      check(cs_falls == 0, "R7 no frame", cs_falls, 0);
      check(exp_idx == 0, "R7 no writes", exp_idx, 0);
      check(done_cyc == 1, "R7 done time", done_cyc, 1);
    end
  endtask

  initial begin
    run_copy(1'b1, 1'b0, 1'b0);   // plain copy
    run_copy(1'b1, 1'b1, 1'b0);   // back-pressure
    run_copy(1'b0, 1'b0, 1'b0);   // disabled
    run_copy(1'b1, 1'b1, 1'b1);   // enable dropped mid-copy, R8
    run_copy(1'b0, 1'b0, 1'b1);   // enable raised after release, R8
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule